// File: doc/BRIEF.md
# Main Clock Source Switch Interlock

This block produces the main system clock from one of three running sources and guards every change of source. A first glitch-free mux picks the high-speed clock from either the crystal oscillator or the PLL output. A second glitch-free mux then picks the main clock from either that high-speed clock or the internal oscillator. Each mux gates the old clock off on its own falling edge. The new clock is enabled only after the select has passed through a synchroniser in the new clock's domain.

Control comes from a single register word written in the internal-oscillator domain. The block checks every write against the clock interlocks before applying it. A field change that would break a rule is dropped, and a sticky reject flag records it. The hardware enforces these rules:
- It refuses to reselect the high-speed source while the main clock uses it.
- It refuses to let the crystal be picked before the crystal reports good.
- It refuses to stop the crystal while the main clock or an active PLL depends on it.
- It raises a status bit while the main mux has left the internal oscillator, and clears that bit once the switch back has finished.

Top module: `mclk_switch`

## Requirements
- R1: After reset the main clock follows the internal oscillator, `hs_active` is 0, `xtal_en` and `pll_ref_xtal` are 0 and `rej_flags` is 0.
- R2: Writing control bit 3 (use high-speed) as 1 with bit 2 (high-speed source: 1 crystal, 0 PLL) at 0 makes the main clock follow the PLL clock and sets `hs_active`.
- R3: With bit 2 at 1, crystal good and bit 3 set, the main clock follows the crystal clock.
- R4: Writing bit 3 as 0 returns the main clock to the internal oscillator, and `hs_active` then reads 0.
- R5: A write that changes bit 2 while bit 3 is set or `hs_active` is 1 leaves the high-speed source unchanged and sets `rej_flags[0]`.
- R6: Any of the following writes, made while `xtal_good` is 0, is dropped and sets `rej_flags[1]`:
  - a write setting bit 2 to 1;
  - a write setting bit 0 (PLL reference is crystal) to 1;
  - a write setting bit 3 to 1 when the crystal would be the high-speed source.
- R7: A write clearing bit 1 (crystal enable) while bit 3 is set, or while `hs_active` is 1, leaves `xtal_en` at 1 and sets `rej_flags[2]`.
- R8: A write clearing bit 1 while `pll_ref_xtal` is 1, `pll_en` is 1 and `pll_off` is 0 leaves `xtal_en` at 1 and sets `rej_flags[3]`.
- R9: Each reject flag stays set until a cycle in which the matching `rej_clr` bit is 1. A new reject in that same cycle keeps the flag set.
- R10: The main clock never shows a high or low phase shorter than the shortest half-period of its sources, including during source changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock; also clocks the control register |
| xtal_clk | input | 1 | Crystal oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word: [3] use high-speed, [2] high-speed source is crystal, [1] crystal enable, [0] PLL reference is crystal |
| rej_clr | input | 4 | Per-bit clear of the reject flags |
| xtal_good | input | 1 | Crystal started and stable |
| pll_en | input | 1 | PLL enabled |
| pll_off | input | 1 | PLL reported fully off |
| mclk | output | 1 | Main system clock |
| hs_active | output | 1 | Main mux is off the internal oscillator |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_ref_xtal | output | 1 | PLL reference select, 1 for crystal |
| rej_flags | output | 4 | Sticky reject flags: [0] source change in use, [1] crystal not good, [2] crystal stop in use, [3] crystal stop under PLL |

## Verification
The bench builds the block with a three-stage synchroniser rather than the default two. This lengthens the window in which `hs_active` is raised but the high-speed side is not yet enabled, and the interlocks must keep holding writes off during that window. The sources have three different periods (8, 20 and 6 ns), so a wrong mux path shows up as a mismatch in the sampled clock, and phase widths can be measured across each handover.

// File: rtl/mclk_sw_pkg.sv
`timescale 1ns/100ps
package mclk_sw_pkg;

    typedef struct packed {
        logic use_hs;
        logic hs_xtal;
        logic xtal_en;
        logic pll_ref;
    } ctl_t;

    localparam int REJ_W       = 4;
    localparam int REJ_HSSEL   = 0;
    localparam int REJ_NOTGOOD = 1;
    localparam int REJ_OFF_HS  = 2;
    localparam int REJ_OFF_PLL = 3;

    function automatic logic going_low(input logic cur, input logic req);
        return cur && !req;
    endfunction

    function automatic logic going_high(input logic cur, input logic req);
        return !cur && req;
    endfunction

endpackage

// File: rtl/gf_clk_mux.sv
`timescale 1ns/100ps
module gf_clk_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk0,
    input  logic clk1,
    input  logic rst,
    input  logic sel,
    output logic en0,
    output logic en1,
    output logic clk_out
);
    localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [N-1:0] chain0, chain1;
    logic         req0, req1;

    assign req0 = !sel && !en1;
    assign req1 =  sel && !en0;

    always_ff @(posedge clk0) begin
        if (rst) chain0 <= '1;
        else     chain0 <= {chain0[N-2:0], req0};
    end

    always_ff @(negedge clk0) begin
        if (rst) en0 <= 1'b1;
        else     en0 <= chain0[N-1];
    end

    always_ff @(posedge clk1) begin
        if (rst) chain1 <= '0;
        else     chain1 <= {chain1[N-2:0], req1};
    end

    always_ff @(negedge clk1) begin
        if (rst) en1 <= 1'b0;
        else     en1 <= chain1[N-1];
    end

    assign clk_out = (clk0 && en0) || (clk1 && en1);

    // R10
    no_overlap_chk: assert property (@(posedge clk0) disable iff (rst) !(en0 && en1));

endmodule

// File: rtl/mclk_ctl_regs.sv
`timescale 1ns/100ps
module mclk_ctl_regs
    import mclk_sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ctl_t             wr_data,
    input  logic [REJ_W-1:0] rej_clr,
    input  logic             xtal_good,
    input  logic             pll_en,
    input  logic             pll_off,
    input  logic             hs_active,
    output ctl_t             ctl_q,
    output logic [REJ_W-1:0] rej_q
);
    ctl_t             nxt;
    logic [REJ_W-1:0] rej_set;
    logic             busy;

    assign busy = ctl_q.use_hs || hs_active;

    always_comb begin
        nxt     = ctl_q;
        rej_set = '0;
        if (wr_en) begin
            if (wr_data.hs_xtal != ctl_q.hs_xtal) begin
                if (busy)                             rej_set[REJ_HSSEL]   = 1'b1;
                else if (wr_data.hs_xtal && !xtal_good) rej_set[REJ_NOTGOOD] = 1'b1;
                else                                  nxt.hs_xtal          = wr_data.hs_xtal;
            end
            if (going_high(ctl_q.use_hs, wr_data.use_hs) && nxt.hs_xtal && !xtal_good)
                rej_set[REJ_NOTGOOD] = 1'b1;
            else
                nxt.use_hs = wr_data.use_hs;
            if (going_high(ctl_q.pll_ref, wr_data.pll_ref) && !xtal_good)
                rej_set[REJ_NOTGOOD] = 1'b1;
            else
                nxt.pll_ref = wr_data.pll_ref;
            if (going_low(ctl_q.xtal_en, wr_data.xtal_en)) begin
                if (busy || nxt.use_hs)                   rej_set[REJ_OFF_HS]  = 1'b1;
                else if (ctl_q.pll_ref && pll_en && !pll_off) rej_set[REJ_OFF_PLL] = 1'b1;
                else                                      nxt.xtal_en          = 1'b0;
            end else begin
                nxt.xtal_en = wr_data.xtal_en;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            rej_q <= '0;
        end else begin
            ctl_q <= nxt;
            rej_q <= (rej_q & ~rej_clr) | rej_set;
        end
    end

    // R5
    hs_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.use_hs || hs_active) |=> $stable(ctl_q.hs_xtal));
    // R6
    pll_ref_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.pll_ref) |-> $past(xtal_good));
    // R7
    xtal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.use_hs || hs_active) && ctl_q.xtal_en) |=> ctl_q.xtal_en);
    // R8
    pll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.pll_ref && pll_en && !pll_off && ctl_q.xtal_en) |=> ctl_q.xtal_en);
    // R9
    rej_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(|($past(rej_q) & ~rej_q & ~$past(rej_clr))));

endmodule

// File: rtl/mclk_switch.sv
`timescale 1ns/100ps
module mclk_switch
    import mclk_sw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             xtal_clk,
    input  logic             pll_clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       wr_data,
    input  logic [REJ_W-1:0] rej_clr,
    input  logic             xtal_good,
    input  logic             pll_en,
    input  logic             pll_off,
    output logic             mclk,
    output logic             hs_active,
    output logic             xtal_en,
    output logic             pll_ref_xtal,
    output logic [REJ_W-1:0] rej_flags
);
    ctl_t ctl_q;
    logic hs_clk;
    logic hs_en_pll, hs_en_xtal;
    logic main_en_osc, main_en_hs;

    mclk_ctl_regs u_regs (
        .clk       (osc_clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (ctl_t'(wr_data)),
        .rej_clr   (rej_clr),
        .xtal_good (xtal_good),
        .pll_en    (pll_en),
        .pll_off   (pll_off),
        .hs_active (hs_active),
        .ctl_q     (ctl_q),
        .rej_q     (rej_flags)
    );

    gf_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_hs_mux (
        .clk0    (pll_clk),
        .clk1    (xtal_clk),
        .rst     (rst),
        .sel     (ctl_q.hs_xtal),
        .en0     (hs_en_pll),
        .en1     (hs_en_xtal),
        .clk_out (hs_clk)
    );

    gf_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_main_mux (
        .clk0    (osc_clk),
        .clk1    (hs_clk),
        .rst     (rst),
        .sel     (ctl_q.use_hs),
        .en0     (main_en_osc),
        .en1     (main_en_hs),
        .clk_out (mclk)
    );

    assign hs_active    = !main_en_osc;
    assign xtal_en      = ctl_q.xtal_en;
    assign pll_ref_xtal = ctl_q.pll_ref;

    // R4
    hs_status_chk: assert property (@(posedge osc_clk) disable iff (rst)
        main_en_hs |-> hs_active);
    // R10
    hs_no_overlap_chk: assert property (@(posedge osc_clk) disable iff (rst)
        !(hs_en_pll && hs_en_xtal));

endmodule

// File: tb/test_mclk_switch.sv
`timescale 1ns/100ps
module test_mclk_switch;
    logic osc_clk = 1'b0, xtal_clk = 1'b0, pll_clk = 1'b0;
    logic rst = 1'b1, wr_en = 1'b0;
    logic [3:0] wr_data = '0, rej_clr = '0;
    logic xtal_good = 1'b0, pll_en = 1'b0, pll_off = 1'b1;
    logic mclk, hs_active, xtal_en, pll_ref_xtal;
    logic [3:0] rej_flags;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4  osc_clk  = ~osc_clk;
    always #10 xtal_clk = ~xtal_clk;
    always #3  pll_clk  = ~pll_clk;

    mclk_switch #(.SYNC_STAGES(3)) i_mclk_switch (
        .osc_clk, .xtal_clk, .pll_clk, .rst, .wr_en, .wr_data, .rej_clr,
        .xtal_good, .pll_en, .pll_off, .mclk, .hs_active, .xtal_en,
        .pll_ref_xtal, .rej_flags
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference of the control word and reject flags
    bit m_use, m_hs, m_xen, m_pref;
    bit [3:0] m_rej;
    always @(posedge osc_clk) begin
        bit [3:0] s;
        bit n_use, n_hs, n_xen, n_pref, inuse;
        if (rst) begin
            {m_use, m_hs, m_xen, m_pref} <= '0;
            m_rej <= '0;
        end else begin
            s = '0;
            {n_use, n_hs, n_xen, n_pref} = {m_use, m_hs, m_xen, m_pref};
            inuse = m_use || hs_active;
            if (wr_en) begin
                if (wr_data[2] != m_hs)
                    if (inuse) s[0] = 1;
                    else if (wr_data[2] && !xtal_good) s[1] = 1;
                    else n_hs = wr_data[2];
                if (wr_data[3] && !m_use && n_hs && !xtal_good) s[1] = 1;
                else n_use = wr_data[3];
                if (wr_data[0] && !m_pref && !xtal_good) s[1] = 1;
                else n_pref = wr_data[0];
                if (m_xen && !wr_data[1]) begin
                    if (inuse || n_use) s[2] = 1;
                    else if (m_pref && pll_en && !pll_off) s[3] = 1;
                    else n_xen = 0;
                end else n_xen = wr_data[1];
            end
            {m_use, m_hs, m_xen, m_pref} <= {n_use, n_hs, n_xen, n_pref};
            m_rej <= (m_rej & ~rej_clr) | s;
        end
    end

    // compared on every clock away from the active edge
    always @(negedge osc_clk) begin
        if (!rst && !done) begin
            chk("R9 rej_flags vs model", rej_flags, m_rej);
            chk("R7/R8 xtal_en vs model", xtal_en, m_xen);
            chk("R6 pll_ref_xtal vs model", pll_ref_xtal, m_pref);
        end
    end

    // R10 phase width monitor
    bit mon_on = 0, mon_started = 0;
    realtime last_t, min_ph = 1000.0;
    always @(mclk) begin
        if (mon_on) begin
            if (mon_started && ($realtime - last_t) < min_ph) min_ph = $realtime - last_t;
            last_t = $realtime;
            mon_started = 1;
        end
    end

    task automatic wr(input logic [3:0] d);
        @(negedge osc_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge osc_clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    // 0 = oscillator, 1 = crystal, 2 = PLL
    task automatic check_src(input string req, input int src);
        int bad = 0;
        logic ref_v;
        @(posedge osc_clk);
        #0.5;
        for (int k = 0; k < 64; k++) begin
            ref_v = (src == 0) ? osc_clk : (src == 1) ? xtal_clk : pll_clk;
            if (mclk !== ref_v) bad++;
            #1;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        #(200000 * 8);
        $display("FAIL watchdog actual=timeout expected=finish");
        fails++;
        checks++;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (6) @(negedge osc_clk);
        rst = 1'b0;
        mon_on = 1;
        idle(4);
        // R1
        check_src("R1 main clock on oscillator", 0);
        chk("R1 hs_active", hs_active, 0);
        chk("R1 rej_flags", rej_flags, 0);

        // R2: high-speed path from PLL
        wr(4'b1000);
        idle(30);
        check_src("R2 main clock on PLL", 2);
        chk("R2 hs_active", hs_active, 1);

        // R5: source change while in use
        xtal_good = 1'b1;
        wr(4'b1100);
        idle(30);
        check_src("R5 source unchanged", 2);
        chk("R5 rej bit0", rej_flags[0], 1);

        // R4: switch back
        wr(4'b0000);
        idle(30);
        check_src("R4 back on oscillator", 0);
        chk("R4 hs_active cleared", hs_active, 0);

        // R6: crystal not good
        xtal_good = 1'b0;
        wr(4'b0101);
        idle(2);
        chk("R6 rej bit1", rej_flags[1], 1);
        chk("R6 pll_ref_xtal held", pll_ref_xtal, 0);
        wr(4'b1000);
        idle(30);
        check_src("R6 PLL path still allowed", 2);
        wr(4'b0000);
        idle(30);

        // R9: sticky then clear
        chk("R9 flags sticky", rej_flags, 4'b0011);
        @(negedge osc_clk); rej_clr = 4'b0001;
        @(negedge osc_clk); rej_clr = 4'b0000;
        chk("R9 bit0 cleared only", rej_flags, 4'b0010);
        @(negedge osc_clk); rej_clr = 4'b0010; wr_en = 1'b1; wr_data = 4'b0001;
        @(negedge osc_clk); rej_clr = 4'b0000; wr_en = 1'b0;
        chk("R9 set wins over clear", rej_flags, 4'b0010);
        @(negedge osc_clk); rej_clr = 4'b1111;
        @(negedge osc_clk); rej_clr = 4'b0000;
        chk("R9 all cleared", rej_flags, 0);

        // R3: crystal path
        xtal_good = 1'b1;
        wr(4'b0110);
        idle(20);
        wr(4'b1110);
        idle(40);
        check_src("R3 main clock on crystal", 1);

        // R7: crystal stop while in use
        wr(4'b1100);
        idle(2);
        chk("R7 xtal_en held", xtal_en, 1);
        chk("R7 rej bit2", rej_flags[2], 1);

        // R8: crystal stop under PLL
        wr(4'b0110);
        idle(40);
        check_src("R4 back on oscillator from crystal", 0);
        wr(4'b0111);
        pll_en = 1'b1; pll_off = 1'b0;
        wr(4'b0101);
        idle(2);
        chk("R8 xtal_en held", xtal_en, 1);
        chk("R8 rej bit3", rej_flags[3], 1);
        pll_en = 1'b0; pll_off = 1'b1;
        wr(4'b0101);
        idle(2);
        chk("R8 crystal stops once PLL off", xtal_en, 0);

        // R10
        mon_on = 0;
        chk("R10 min phase >= 3ns", (min_ph >= 2.9) ? 1 : 0, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule